// File: doc/BRIEF.md
# Shift-Add Vector Magnitude Estimator

This block gives a fast estimate of the length of a complex sample without a multiplier or a square root. Each cycle it can accept a signed in-phase/quadrature pair. It takes the absolute value of both parts and sorts them into a larger part (Max) and a smaller part (Min). It then forms alpha·Max + beta·Min, where every coefficient is a power of two or a difference of two. All of these are built from hardwired right shifts that truncate, together with adders and subtractors.

A three-bit mode input chooses the coefficient pair. The mode is captured with each sample and travels down the pipeline with it, so neighbouring samples may use different pairs. The two tapered pairs are formed from the base sum S = Max + floor(Min/2) by subtracting a shifted copy of S. These are S − floor(S/8) and S − floor(S/16).

The estimate can run up to about 12 % above the true magnitude. For that reason the internal sum carries one bit more than the absolute values. A result that does not fit the output width is clamped to all ones and flagged.

Top module: `vecmag_est`

## Requirements
- R1: Each input part is treated as N-bit two's complement. Its absolute value is taken before sorting. The most negative code, -2^(N-1), is clamped to 2^(N-1)-1.
- R2: Max is the larger of |I| and |Q| and Min is the smaller. On a tie, either part serves as both. The result therefore does not change when the signs of I or Q flip, or when I and Q are exchanged.
- R3: Mode 0 (alpha 1, beta 1/2) outputs Max + floor(Min/2).
- R4: Mode 1 (alpha 1, beta 1/4) outputs Max + floor(Min/4).
- R5: Mode 2 (alpha 1, beta 3/8) outputs Max + floor(Min/4) + floor(Min/8).
- R6: Mode 3 (alpha 7/8, beta 7/16) outputs S - floor(S/8), with S = Max + floor(Min/2) computed with one extra bit of width.
- R7: Mode 4 (alpha 15/16, beta 15/32) outputs S - floor(S/16).
- R8: Mode codes 5, 6 and 7 behave exactly like mode 0.
- R9: When the estimate is 2^OUT_W or more, out_ovf is 1 and out_mag is all ones. Otherwise out_ovf is 0 and out_mag carries the estimate.
- R10: out_valid rises exactly three clock edges after the edge that samples in_valid high. One result is produced per cycle when inputs arrive back to back.
- R11: The mode is captured with each sample. A change of mode between consecutive samples affects only the samples that carry the new code.
- R12: A synchronous active-high reset clears out_valid, out_mag and out_ovf, and discards samples that are in flight.
- R13: While out_valid is 0, out_mag and out_ovf are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_i, in_q and in_mode |
| in_i | input | N | In-phase part, two's complement |
| in_q | input | N | Quadrature part, two's complement |
| in_mode | input | 3 | Coefficient pair select (0..4; 5..7 act as 0) |
| out_valid | output | 1 | Qualifies out_mag and out_ovf |
| out_mag | output | OUT_W | Unsigned magnitude estimate |
| out_ovf | output | 1 | Estimate exceeded the output range; out_mag clamped |

## Verification
The bench targets the most negative input code. A design without the clamp would wrap it to a small or negative value and report a tiny magnitude. It also targets equal and sign-mixed parts, where a wrong swap would weight the smaller part as alpha. Truncation is checked on odd values, where rounding instead of truncating would move each result by one. Sums that exceed the output range only before the taper subtraction are included. A design without the extra internal bit would report a wrapped, wrong result for them, and one that clamped too early would flag an overflow that is not there. Finally, the bench alternates modes between back-to-back samples and resets with samples in flight. This exposes a mode that is not carried down the pipeline and leftover outputs after reset.

// File: rtl/vm_pkg.sv
package vm_pkg;
  typedef logic [2:0] mode_t;

  localparam mode_t MODE_HALF      = 3'd0;
  localparam mode_t MODE_QUARTER   = 3'd1;
  localparam mode_t MODE_THREE8    = 3'd2;
  localparam mode_t MODE_SEVEN8    = 3'd3;
  localparam mode_t MODE_FIFTEEN16 = 3'd4;

  localparam int MODE_W = 3;
endpackage

// File: rtl/vm_abs_stage.sv
module vm_abs_stage
  import vm_pkg::*;
#(
  parameter int N = 16,
  localparam int AW = N - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [N-1:0]  in_i,
  input  logic [N-1:0]  in_q,
  input  mode_t         in_mode,
  output logic          s1_valid,
  output logic [AW-1:0] s1_abs_i,
  output logic [AW-1:0] s1_abs_q,
  output mode_t         s1_mode,
  output logic [1:0]    clamp_ev
);
  // Magnitude of a two's complement word, with the one unrepresentable
  // value folded onto the largest positive one.
  function automatic logic [AW-1:0] clamp_abs(input logic [N-1:0] x);
    logic [N-1:0] neg;
    neg = -x;
    if (x[N-1] && (x[AW-1:0] == '0)) return {AW{1'b1}};
    else if (x[N-1])                  return neg[AW-1:0];
    else                              return x[AW-1:0];
  endfunction

  logic [N-1:0]  lane_in  [2];
  logic [AW-1:0] lane_abs [2];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_abs[g] = clamp_abs(lane_in[g]);
    assign clamp_ev[g] = in_valid && lane_in[g][N-1] && (lane_in[g][AW-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_abs_i <= '0;
      s1_abs_q <= '0;
      s1_mode  <= MODE_HALF;
    end else begin
      s1_valid <= in_valid;
      s1_abs_i <= lane_abs[0];
      s1_abs_q <= lane_abs[1];
      s1_mode  <= in_mode;
    end
  end
endmodule

// File: rtl/vm_sort_sum.sv
module vm_sort_sum
  import vm_pkg::*;
#(
  parameter int AW = 15,
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_valid,
  input  logic [AW-1:0] s1_abs_i,
  input  logic [AW-1:0] s1_abs_q,
  input  mode_t         s1_mode,
  output logic [AW-1:0] cmp_max,
  output logic [AW-1:0] cmp_min,
  output logic          swap_ev,
  output logic [SW-1:0] pre_sum,
  output logic          s2_valid,
  output logic [SW-1:0] s2_sum,
  output mode_t         s2_mode
);
  // The beta term before the alpha taper: a shift or a pair of shifts.
  function automatic logic [AW-1:0] beta_term(input logic [AW-1:0] mn, input mode_t m);
    case (m)
      MODE_QUARTER: return mn >> 2;
      MODE_THREE8:  return (mn >> 2) + (mn >> 3);
      default:      return mn >> 1;
    endcase
  endfunction

  logic i_larger;

  assign i_larger = s1_abs_i > s1_abs_q;
  assign swap_ev  = s1_valid && !i_larger;
  assign cmp_max  = i_larger ? s1_abs_i : s1_abs_q;
  assign cmp_min  = i_larger ? s1_abs_q : s1_abs_i;
  assign pre_sum  = {1'b0, cmp_max} + {1'b0, beta_term(cmp_min, s1_mode)};

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_sum   <= '0;
      s2_mode  <= MODE_HALF;
    end else begin
      s2_valid <= s1_valid;
      s2_sum   <= pre_sum;
      s2_mode  <= s1_mode;
    end
  end
endmodule

// File: rtl/vm_scale_out.sv
module vm_scale_out
  import vm_pkg::*;
#(
  parameter int SW    = 16,
  parameter int OUT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic [SW-1:0]    s2_sum,
  input  mode_t            s2_mode,
  output logic [SW-1:0]    scaled,
  output logic             range_ev,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_mag,
  output logic             out_ovf
);
  // Alpha taper: 1, 7/8 or 15/16 of the base sum, by truncating shifts.
  function automatic logic [SW-1:0] taper(input logic [SW-1:0] s, input mode_t m);
    case (m)
      MODE_SEVEN8:    return s - (s >> 3);
      MODE_FIFTEEN16: return s - (s >> 4);
      default:        return s;
    endcase
  endfunction

  assign scaled   = taper(s2_sum, s2_mode);
  assign range_ev = s2_valid && ((scaled >> OUT_W) != '0);

  always_ff @(posedge clk) begin
    if (rst || !s2_valid) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      out_ovf   <= range_ev;
      out_mag   <= range_ev ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/vecmag_est.sv
module vecmag_est
  import vm_pkg::*;
#(
  parameter int N     = 16,
  parameter int OUT_W = N - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N-1:0]     in_i,
  input  logic [N-1:0]     in_q,
  input  logic [2:0]       in_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_mag,
  output logic             out_ovf
);
  localparam int AW = N - 1;
  localparam int SW = AW + 1;

  logic          s1_valid;
  logic [AW-1:0] s1_abs_i;
  logic [AW-1:0] s1_abs_q;
  mode_t         s1_mode;
  logic [1:0]    clamp_ev;

  logic [AW-1:0] cmp_max;
  logic [AW-1:0] cmp_min;
  logic          swap_ev;
  logic [SW-1:0] pre_sum;
  logic          s2_valid;
  logic [SW-1:0] s2_sum;
  mode_t         s2_mode;

  logic [SW-1:0] scaled;
  logic          range_ev;

  vm_abs_stage #(.N(N)) u_abs (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .in_mode  (mode_t'(in_mode)),
    .s1_valid (s1_valid),
    .s1_abs_i (s1_abs_i),
    .s1_abs_q (s1_abs_q),
    .s1_mode  (s1_mode),
    .clamp_ev (clamp_ev)
  );

  vm_sort_sum #(.AW(AW)) u_sort (
    .clk      (clk),
    .rst      (rst),
    .s1_valid (s1_valid),
    .s1_abs_i (s1_abs_i),
    .s1_abs_q (s1_abs_q),
    .s1_mode  (s1_mode),
    .cmp_max  (cmp_max),
    .cmp_min  (cmp_min),
    .swap_ev  (swap_ev),
    .pre_sum  (pre_sum),
    .s2_valid (s2_valid),
    .s2_sum   (s2_sum),
    .s2_mode  (s2_mode)
  );

  vm_scale_out #(.SW(SW), .OUT_W(OUT_W)) u_scale (
    .clk       (clk),
    .rst       (rst),
    .s2_valid  (s2_valid),
    .s2_sum    (s2_sum),
    .s2_mode   (s2_mode),
    .scaled    (scaled),
    .range_ev  (range_ev),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .out_ovf   (out_ovf)
  );
endmodule

// File: rtl/vecmag_est_chk.sv
module vecmag_est_chk #(
  parameter int N     = 16,
  parameter int OUT_W = N - 1,
  localparam int AW = N - 1,
  localparam int SW = AW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [N-1:0]     in_i,
  input logic [N-1:0]     in_q,
  input logic             s1_valid,
  input logic [AW-1:0]    cmp_max,
  input logic [AW-1:0]    cmp_min,
  input logic [SW-1:0]    pre_sum,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_mag,
  input logic             out_ovf
);
  localparam int TOP = (1 << (N - 1)) - 1;

  function automatic int mag_of(input logic [N-1:0] x);
    int v;
    v = int'($signed(x));
    if (v < 0) v = -v;
    return (v > TOP) ? TOP : v;
  endfunction

  logic [2:0] vsh;
  int         mx_d [3];
  int         mx_now;

  assign mx_now = (mag_of(in_i) > mag_of(in_q)) ? mag_of(in_i) : mag_of(in_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh <= '0;
      for (int k = 0; k < 3; k++) mx_d[k] <= 0;
    end else begin
      vsh     <= {vsh[1:0], in_valid};
      mx_d[0] <= mx_now;
      mx_d[1] <= mx_d[0];
      mx_d[2] <= mx_d[1];
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[2]); // R10

  AST_OVF_CLAMP: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (&out_mag)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_mag == '0 && !out_ovf)); // R13

  AST_SORTED: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (cmp_max >= cmp_min)); // R2

  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (pre_sum >= {1'b0, cmp_max} &&
                  pre_sum <= {1'b0, cmp_max} + SW'(cmp_min >> 1))); // R3

  AST_MAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ovf) |-> (8 * int'(out_mag) >= 7 * mx_d[2] &&
                                 int'(out_mag) <= mx_d[2] + mx_d[2] / 2)); // R6
endmodule

bind vecmag_est vecmag_est_chk #(.N(N), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_i      (in_i),
  .in_q      (in_q),
  .s1_valid  (s1_valid),
  .cmp_max   (cmp_max),
  .cmp_min   (cmp_min),
  .pre_sum   (pre_sum),
  .out_valid (out_valid),
  .out_mag   (out_mag),
  .out_ovf   (out_ovf)
);

// File: tb/vecmag_est_test.sv
module vecmag_est_test;
  localparam int N     = 16;
  localparam int OUT_W = 15;
  localparam int NV    = 20;

  // mode, I, Q, expected magnitude, expected overflow
  localparam int T_MODE [NV] = '{0, 0, 0, 1, 2, 3, 4, 5, 7, 0,
                                 0, 4, 0, 0, 3, 0, 4, 3, 2, 1};
  localparam int T_I    [NV] = '{100, -40, -100, 1000, 1000, 1000, 1000, 1000, 7, -32768,
                                 -32768, 30000, 30000, 30000, 30000, 0, 1, -9, 15, -32767};
  localparam int T_Q    [NV] = '{40, 100, -41, 999, 999, 999, 999, 999, 3, 0,
                                 -32768, 5000, 5000, 6000, 6000, 0, 1, 17, -15, 32767};
  localparam int T_MAG  [NV] = '{120, 120, 120, 1249, 1373, 1312, 1406, 1499, 8, 32767,
                                 32767, 30469, 32500, 32767, 28875, 0, 1, 19, 19, 32767};
  localparam int T_OVF  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                 1, 0, 0, 1, 0, 0, 0, 0, 0, 1};
  localparam string T_TAG [NV] = '{"R3", "R2", "R2", "R4", "R5", "R6", "R7", "R8", "R8", "R1",
                                   "R9", "R7", "R3", "R9", "R6", "R3", "R7", "R6", "R5", "R9"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [N-1:0]     in_i = '0;
  logic [N-1:0]     in_q = '0;
  logic [2:0]       in_mode = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_mag;
  logic             out_ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vecmag_est #(.N(N), .OUT_W(OUT_W)) uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .out_ovf   (out_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int m, input int i, input int q);
    in_valid = 1'b1;
    in_mode  = 3'(m);
    in_i     = N'(i);
    in_q     = N'(q);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_i     = '0;
    in_q     = '0;
    in_mode  = '0;
  endtask

  initial begin
    int rd;
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 reset valid", int'(out_valid), 0);
    chk("R12 reset mag", int'(out_mag), 0);
    chk("R12 reset ovf", int'(out_ovf), 0);
    rst = 1'b0;

    // Table walk, back to back with per-sample mode changes (R10, R11)
    rd = 0;
    for (int k = 0; k < NV + 4; k++) begin
      @(negedge clk);
      if (out_valid) begin
        if (rd < NV) begin
          chk({T_TAG[rd], " mag"}, int'(out_mag), T_MAG[rd]);
          chk({T_TAG[rd], " ovf"}, int'(out_ovf), T_OVF[rd]);
        end
        rd++;
      end
      if (k < NV) drive(T_MODE[k], T_I[k], T_Q[k]);
      else idle();
    end
    chk("R10 one result per sample (R11 modes kept apart)", rd, NV);

    // R10 / R13: single sample latency and idle outputs
    @(negedge clk);
    drive(3, 1000, 999);
    @(negedge clk);
    idle();
    chk("R10 edge1 valid", int'(out_valid), 0);
    chk("R13 edge1 mag", int'(out_mag), 0);
    @(negedge clk);
    chk("R10 edge2 valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R10 edge3 valid", int'(out_valid), 1);
    chk("R6 edge3 mag", int'(out_mag), 1312);
    @(negedge clk);
    chk("R13 after valid", int'(out_valid), 0);
    chk("R13 after mag", int'(out_mag), 0);
    chk("R13 after ovf", int'(out_ovf), 0);

    // R12: reset with an overflowing sample in flight
    drive(0, -32768, -32768);
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R12 flushed valid", int'(out_valid), 0);
      chk("R12 flushed ovf", int'(out_ovf), 0);
    end

    // R2: swapped and negated parts give the same odd-valued result
    drive(0, 33, -77);
    @(negedge clk);
    drive(0, 77, 33);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R2 swap a", int'(out_mag), 93);
    @(negedge clk);
    chk("R2 swap b", int'(out_mag), 93);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule